// File: doc/BRIEF.md
# Multiplexed LCD and Key-Scan Driver

This block produces the drive pattern for a three-common, one-third-duty, half-bias liquid-crystal panel, and it scans a small key matrix through the same pins. It does not produce voltages. Each common and each segment pin carries a 2-bit level code (`00` ground, `01` half level, `10` full LCD voltage), and an analog stage outside the block turns the code into a voltage. A segment RAM image tells the block which segment is lit under which common. A tick of about 500 Hz steps the frame, so each common phase lasts about 2 ms and a frame of six phases repeats at about 83 Hz.

Eight of the segment pins double as key-return strobes. Every tick opens a short key slot of `SLOT_CYC` clock cycles. During the slot one of those eight pins pulls low and the other seven are driven high. At the last cycle of the slot the block samples the 4-bit key port, whose lines are pulled up, and stores the inverted nibble (1 = pressed) in that strobe's latch. This builds a 32-key map. Between slots the shared pins show display data.

A clock-stop request forces every pin to ground and keeps the key map. After reset or clock-stop, the display stays parked at the half level until software clears the display-off bit (a 1-to-0 transition). A pull-down key mode stops the scan and raises a wake flag while any key line is high.

Top module: `lcd_keyscan`

## Requirements
- R1: After reset all common and segment codes are `01`, no strobe is active, and the 32-bit key map reads zero.
- R2: While `disp_off_i` is 1, all commons and all non-strobing segments read `01`, and the phase returns to 0. When the bit is cleared, the frame restarts at phase 0 on the next cycle.
- R3: When running, the frame has 6 phases and one tick moves it one phase. In phase p the common p mod 3 reads `10` for p<3 and `00` for p>=3, and the other two commons read `01`.
- R4: A segment lit under the active common takes the opposite code (`00`/`10`) of that common, and an unlit segment takes the same code. Segment j under common c is bit c*23+j of `seg_ram_i`.
- R5: Each tick opens a key slot of `SLOT_CYC` cycles. Exactly one strobe bit is active during the slot, and none outside it. Successive slots step through strobes 0..7 and then wrap to 0.
- R6: During a slot, strobe k drives segment pin 22-k to `00`, and the other pins of indices 15..22 read `10`. Pins 0..14 keep their display codes.
- R7: At the last cycle of a slot, `~key_in_i` is stored into `key_map_o[4k+3:4k]` for the current strobe k. The key map changes at no other time.
- R8: While `clk_stop_i` is 1, all common and segment codes are `00` and no strobe is active. The key map keeps its contents.
- R9: After a clock-stop is released, the commons stay at `01` (even across ticks) until `disp_off_i` goes from 1 to 0.
- R10: While `kin_pd_i` is 1, no key slot runs and the key map holds. `wake_o` equals the OR of `key_in_i`, and it is 0 when `kin_pd_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_i | input | 1 | One-cycle pulse per common phase (about 500 Hz) |
| seg_ram_i | input | 69 | Lit bits, index c*23+j |
| disp_off_i | input | 1 | Display-off bit |
| clk_stop_i | input | 1 | Clock-stop (back-up) request |
| kin_pd_i | input | 1 | Key port in pull-down wake mode |
| key_in_i | input | 4 | Key input port |
| com_o | output | 6 | Common level codes, 2 bits each |
| seg_o | output | 46 | Segment level codes, 2 bits each |
| kr_strobe_o | output | 8 | Active key-return strobe, one-hot or zero |
| key_map_o | output | 32 | Pressed-key map, 4 bits per strobe |
| wake_o | output | 1 | Wake request in pull-down mode |

## Verification
The frame is run with four segment images: all dark, all lit, a striped pattern and a mixed pattern. Each image is stepped through all six phases. Dark and lit tell apart the two segment polarities. The striped and mixed images catch a segment read from the wrong common row or a wrong bit offset. Each image comes with a different key nibble, and 32 slots in total cover all eight strobes and the wrap from 7 back to 0. Each captured nibble is compared against a model of the whole map, which exposes a wrong latch, a missing inversion or a sample taken at the wrong time.

// File: rtl/lcd_ks_pkg.sv
package lcd_ks_pkg;
  typedef enum logic [1:0] {
    LV_GND  = 2'b00,
    LV_HALF = 2'b01,
    LV_FULL = 2'b10
  } lvl_e;

  // common level for a running frame
  function automatic lvl_e lvl_com(input logic active, input logic neg);
    if (!active) return LV_HALF;
    return neg ? LV_GND : LV_FULL;
  endfunction

  // segment level: lit is the inverse of the active common
  function automatic lvl_e lvl_seg(input logic lit, input logic neg);
    return (lit ^ neg) ? LV_GND : LV_FULL;
  endfunction
endpackage

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq #(
  parameter int N_COM = 3,
  localparam int CW = (N_COM > 1) ? $clog2(N_COM) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          stop_i,
  input  logic          disp_off_i,
  output logic          run_o,
  output logic [CW-1:0] act_o,
  output logic          neg_o
);
  logic          run_q;
  logic          off_q;
  logic [CW-1:0] act_q;
  logic          neg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      off_q <= 1'b0;
      act_q <= '0;
      neg_q <= 1'b0;
    end else begin
      off_q <= disp_off_i;
      if (stop_i || disp_off_i) begin
        run_q <= 1'b0;
        act_q <= '0;
        neg_q <= 1'b0;
      end else begin
        if (off_q) run_q <= 1'b1;
        if (run_q && tick_i) begin
          if (act_q == CW'(N_COM - 1)) begin
            act_q <= '0;
            neg_q <= ~neg_q;
          end else begin
            act_q <= act_q + 1'b1;
          end
        end
      end
    end
  end

  assign run_o = run_q;
  assign act_o = act_q;
  assign neg_o = neg_q;
endmodule

// File: rtl/lcd_key_scan.sv
module lcd_key_scan #(
  parameter int N_KR     = 8,
  parameter int N_KEY    = 4,
  parameter int SLOT_CYC = 8,
  localparam int KW = (N_KR > 1) ? $clog2(N_KR) : 1,
  localparam int SW = $clog2(SLOT_CYC + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  stop_i,
  input  logic                  pd_i,
  input  logic [N_KEY-1:0]      key_in_i,
  output logic                  slot_act_o,
  output logic                  sample_evt_o,
  output logic [KW-1:0]         kidx_o,
  output logic [N_KR-1:0]       strobe_o,
  output logic [N_KR*N_KEY-1:0] key_map_o,
  output logic                  wake_o
);
  logic [SW-1:0] left_q;
  logic [KW-1:0] kidx_q;
  logic          slot_act;
  logic          sample_evt;

  assign slot_act   = (left_q != '0) && !stop_i && !pd_i;
  assign sample_evt = slot_act && (left_q == SW'(1)) && !tick_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                left_q <= '0;
    else if (stop_i || pd_i)   left_q <= '0;
    else if (tick_i)           left_q <= SW'(SLOT_CYC);
    else if (left_q != '0)     left_q <= left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               kidx_q <= '0;
    else if (sample_evt) begin
      if (kidx_q == KW'(N_KR - 1)) kidx_q <= '0;
      else                         kidx_q <= kidx_q + 1'b1;
    end
  end

  for (genvar k = 0; k < N_KR; k++) begin : g_latch
    logic [N_KEY-1:0] nib_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   nib_q <= '0;
      else if (sample_evt && kidx_q == KW'(k))      nib_q <= ~key_in_i;
    end
    assign key_map_o[k*N_KEY +: N_KEY] = nib_q;
    assign strobe_o[k] = slot_act && (kidx_q == KW'(k));
  end

  assign slot_act_o   = slot_act;
  assign sample_evt_o = sample_evt;
  assign kidx_o       = kidx_q;
  assign wake_o       = pd_i && (|key_in_i);
endmodule

// File: rtl/lcd_level_mux.sv
module lcd_level_mux
  import lcd_ks_pkg::*;
#(
  parameter int N_COM   = 3,
  parameter int N_SEG   = 23,
  parameter int N_KR    = 8,
  parameter int KR_BASE = 15,
  localparam int CW = (N_COM > 1) ? $clog2(N_COM) : 1,
  localparam int KW = (N_KR > 1) ? $clog2(N_KR) : 1
) (
  input  logic                   stop_i,
  input  logic                   run_i,
  input  logic [CW-1:0]          act_i,
  input  logic                   neg_i,
  input  logic                   slot_act_i,
  input  logic [KW-1:0]          kidx_i,
  input  logic [N_COM*N_SEG-1:0] seg_ram_i,
  output logic [2*N_COM-1:0]     com_o,
  output logic [2*N_SEG-1:0]     seg_o
);
  for (genvar c = 0; c < N_COM; c++) begin : g_com
    lvl_e lv;
    always_comb begin
      if (stop_i)      lv = LV_GND;
      else if (!run_i) lv = LV_HALF;
      else             lv = lvl_com(act_i == CW'(c), neg_i);
    end
    assign com_o[2*c +: 2] = lv;
  end

  for (genvar j = 0; j < N_SEG; j++) begin : g_seg
    logic lit;
    lvl_e lv;
    always_comb begin
      lit = 1'b0;
      for (int c = 0; c < N_COM; c++)
        if (act_i == CW'(c)) lit = seg_ram_i[c*N_SEG + j];
    end
    if (j >= KR_BASE && j < KR_BASE + N_KR) begin : g_shared
      localparam int K = KR_BASE + N_KR - 1 - j;
      always_comb begin
        if (stop_i)          lv = LV_GND;
        else if (slot_act_i) lv = (kidx_i == KW'(K)) ? LV_GND : LV_FULL;
        else if (!run_i)     lv = LV_HALF;
        else                 lv = lvl_seg(lit, neg_i);
      end
    end else begin : g_plain
      always_comb begin
        if (stop_i)      lv = LV_GND;
        else if (!run_i) lv = LV_HALF;
        else             lv = lvl_seg(lit, neg_i);
      end
    end
    assign seg_o[2*j +: 2] = lv;
  end
endmodule

// File: rtl/lcd_keyscan.sv
module lcd_keyscan #(
  parameter int N_COM    = 3,
  parameter int N_SEG    = 23,
  parameter int N_KR     = 8,
  parameter int N_KEY    = 4,
  parameter int KR_BASE  = 15,
  parameter int SLOT_CYC = 8,
  localparam int CW    = (N_COM > 1) ? $clog2(N_COM) : 1,
  localparam int KW    = (N_KR > 1) ? $clog2(N_KR) : 1,
  localparam int RAM_W = N_COM * N_SEG
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic [RAM_W-1:0]      seg_ram_i,
  input  logic                  disp_off_i,
  input  logic                  clk_stop_i,
  input  logic                  kin_pd_i,
  input  logic [N_KEY-1:0]      key_in_i,
  output logic [2*N_COM-1:0]    com_o,
  output logic [2*N_SEG-1:0]    seg_o,
  output logic [N_KR-1:0]       kr_strobe_o,
  output logic [N_KR*N_KEY-1:0] key_map_o,
  output logic                  wake_o
);
  logic          run_w;
  logic [CW-1:0] act_w;
  logic          neg_w;
  logic          slot_act_w;
  logic          sample_evt_w;
  logic [KW-1:0] kidx_w;

  lcd_phase_seq #(.N_COM(N_COM)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .stop_i(clk_stop_i),
    .disp_off_i(disp_off_i), .run_o(run_w), .act_o(act_w), .neg_o(neg_w)
  );

  lcd_key_scan #(.N_KR(N_KR), .N_KEY(N_KEY), .SLOT_CYC(SLOT_CYC)) u_scan (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .stop_i(clk_stop_i),
    .pd_i(kin_pd_i), .key_in_i(key_in_i), .slot_act_o(slot_act_w),
    .sample_evt_o(sample_evt_w), .kidx_o(kidx_w), .strobe_o(kr_strobe_o),
    .key_map_o(key_map_o), .wake_o(wake_o)
  );

  lcd_level_mux #(.N_COM(N_COM), .N_SEG(N_SEG), .N_KR(N_KR), .KR_BASE(KR_BASE)) u_mux (
    .stop_i(clk_stop_i), .run_i(run_w), .act_i(act_w), .neg_i(neg_w),
    .slot_act_i(slot_act_w), .kidx_i(kidx_w), .seg_ram_i(seg_ram_i),
    .com_o(com_o), .seg_o(seg_o)
  );
endmodule

// File: rtl/lcd_keyscan_chk.sv
module lcd_keyscan_chk #(
  parameter int N_COM = 3,
  parameter int N_SEG = 23,
  parameter int N_KR  = 8,
  parameter int N_KEY = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  clk_stop_i,
  input logic                  kin_pd_i,
  input logic [2*N_COM-1:0]    com_o,
  input logic [2*N_SEG-1:0]    seg_o,
  input logic [N_KR-1:0]       kr_strobe_o,
  input logic [N_KR*N_KEY-1:0] key_map_o,
  input logic                  run,
  input logic                  sample_evt
);
  logic [N_COM-1:0] not_half;
  for (genvar c = 0; c < N_COM; c++) begin : g_nh
    assign not_half[c] = (com_o[2*c +: 2] != 2'b01);
  end

  // R8
  stop_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop_i |-> (com_o == '0 && seg_o == '0 && kr_strobe_o == '0));

  // R5
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(kr_strobe_o));

  // R10
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kin_pd_i |-> kr_strobe_o == '0);

  // R2
  park_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clk_stop_i) |-> com_o == {N_COM{2'b01}});

  // R3
  one_active_com_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clk_stop_i) |-> $countones(not_half) == 1);

  // R7
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_evt |=> $stable(key_map_o));

  // R9
  restart_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_stop_i) |-> !run);
endmodule

bind lcd_keyscan lcd_keyscan_chk #(
  .N_COM(N_COM), .N_SEG(N_SEG), .N_KR(N_KR), .N_KEY(N_KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_stop_i(clk_stop_i), .kin_pd_i(kin_pd_i),
  .com_o(com_o), .seg_o(seg_o), .kr_strobe_o(kr_strobe_o),
  .key_map_o(key_map_o), .run(run_w), .sample_evt(sample_evt_w)
);

// File: tb/sim_lcd_keyscan.sv
module sim_lcd_keyscan;
  localparam int SLOT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [68:0] ram = '0;
  logic        doff = 1'b0;
  logic        stop = 1'b0;
  logic        pd = 1'b0;
  logic [3:0]  keys = 4'hF;
  logic [5:0]  com;
  logic [45:0] seg;
  logic [7:0]  strobe;
  logic [31:0] kmap;
  logic        wake;

  int errors = 0;
  int checks = 0;
  int ph = 0;
  int kr = 0;
  logic [31:0] km_exp = '0;

  always #2 clk = ~clk;

  lcd_keyscan u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .seg_ram_i(ram),
    .disp_off_i(doff), .clk_stop_i(stop), .kin_pd_i(pd), .key_in_i(keys),
    .com_o(com), .seg_o(seg), .kr_strobe_o(strobe), .key_map_o(kmap),
    .wake_o(wake)
  );

  typedef struct packed {
    logic [68:0] img;
    logic [3:0]  nib;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{img: 69'h0,                 nib: 4'hF},
    '{img: {69{1'b1}},            nib: 4'h0},
    '{img: {23{3'b010}},          nib: 4'hA},
    '{img: {3{23'h5A5C3}},        nib: 4'h6}
  };

  localparam logic [5:0]  COM_HALF = {3{2'b01}};
  localparam logic [45:0] SEG_HALF = {23{2'b01}};

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_com(input int p);
    logic [5:0] r;
    for (int c = 0; c < 3; c++) begin
      if (c != p % 3)  r[2*c +: 2] = 2'b01;
      else if (p < 3)  r[2*c +: 2] = 2'b10;
      else             r[2*c +: 2] = 2'b00;
    end
    return r;
  endfunction

  // base: display codes or half vector when parked
  function automatic logic [45:0] exp_seg(input logic [68:0] img, input int p,
                                          input bit running, input bit slot, input int k);
    logic [45:0] r;
    for (int j = 0; j < 23; j++) begin
      logic lit;
      lit = img[(p % 3) * 23 + j];
      if (!running)  r[2*j +: 2] = 2'b01;
      else if (p < 3) r[2*j +: 2] = lit ? 2'b00 : 2'b10;
      else            r[2*j +: 2] = lit ? 2'b10 : 2'b00;
      if (slot && j >= 15) r[2*j +: 2] = (22 - j == k) ? 2'b00 : 2'b10;
    end
    return r;
  endfunction

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  // runs one full slot: checks during and after; running selects frame model
  task automatic do_slot(input bit running);
    pulse_tick();
    if (running) ph = (ph + 1) % 6;
    chk(strobe == (8'd1 << kr), "R5 strobe in slot", 64'(strobe), 64'(8'd1 << kr));
    chk(seg == exp_seg(ram, ph, running, 1'b1, kr), "R6 shared pins in slot",
        64'(seg), 64'(exp_seg(ram, ph, running, 1'b1, kr)));
    if (running)
      chk(com == exp_com(ph), "R3 common phase", 64'(com), 64'(exp_com(ph)));
    else
      chk(com == COM_HALF, "R9 commons parked", 64'(com), 64'(COM_HALF));
    repeat (SLOT) @(negedge clk);
    km_exp[kr*4 +: 4] = ~keys;
    kr = (kr + 1) % 8;
    chk(strobe == 8'h00, "R5 strobe off after slot", 64'(strobe), 64'h0);
    chk(kmap == km_exp, "R7 key map", 64'(kmap), 64'(km_exp));
    chk(seg == exp_seg(ram, ph, running, 1'b0, 0), "R4 segment levels",
        64'(seg), 64'(exp_seg(ram, ph, running, 1'b0, 0)));
    repeat (3) @(negedge clk);
  endtask

  task automatic start_frame();
    @(negedge clk) doff = 1'b1;
    @(negedge clk);
    chk(com == COM_HALF, "R2 off parks commons", 64'(com), 64'(COM_HALF));
    chk(seg == SEG_HALF, "R2 off parks segments", 64'(seg), 64'(SEG_HALF));
    doff = 1'b0;
    @(negedge clk);
    ph = 0;
    chk(com == exp_com(0), "R2 restart at phase 0", 64'(com), 64'(exp_com(0)));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(com == COM_HALF, "R1 reset commons", 64'(com), 64'(COM_HALF));
    chk(seg == SEG_HALF, "R1 reset segments", 64'(seg), 64'(SEG_HALF));
    chk(strobe == 8'h00, "R1 reset strobes", 64'(strobe), 64'h0);
    chk(kmap == 32'h0, "R1 reset key map", 64'(kmap), 64'h0);

    // R9: not started without a clear of display-off
    do_slot(1'b0);

    start_frame();

    // table walk: frame images and key nibbles
    foreach (VECS[i]) begin
      ram  = VECS[i].img;
      keys = VECS[i].nib;
      for (int t = 0; t < 8; t++) do_slot(1'b1);
    end

    // R2: display-off mid frame
    start_frame();
    do_slot(1'b1);

    // R8: clock stop
    keys = 4'h3;
    @(negedge clk) stop = 1'b1;
    @(negedge clk);
    chk(com == 6'h0, "R8 stop commons", 64'(com), 64'h0);
    chk(seg == 46'h0, "R8 stop segments", 64'(seg), 64'h0);
    chk(kmap == km_exp, "R8 key map kept", 64'(kmap), 64'(km_exp));
    pulse_tick();
    chk(strobe == 8'h00, "R8 no strobe in stop", 64'(strobe), 64'h0);
    @(negedge clk) stop = 1'b0;
    @(negedge clk);
    chk(com == COM_HALF, "R9 half after release", 64'(com), 64'(COM_HALF));
    ph = 0;
    do_slot(1'b0);
    start_frame();
    do_slot(1'b1);

    // R10: pull-down wake mode
    @(negedge clk) begin pd = 1'b1; keys = 4'h0; end
    @(negedge clk);
    chk(wake == 1'b0, "R10 wake low", 64'(wake), 64'h0);
    keys = 4'b0100;
    @(negedge clk);
    chk(wake == 1'b1, "R10 wake high", 64'(wake), 64'h1);
    pulse_tick();
    ph = (ph + 1) % 6;
    chk(strobe == 8'h00, "R10 no scan", 64'(strobe), 64'h0);
    chk(com == exp_com(ph), "R10 frame continues", 64'(com), 64'(exp_com(ph)));
    repeat (SLOT + 2) @(negedge clk);
    chk(kmap == km_exp, "R10 key map held", 64'(kmap), 64'(km_exp));
    pd = 1'b0;
    @(negedge clk);
    chk(wake == 1'b0, "R10 wake off outside mode", 64'(wake), 64'h0);
    keys = 4'hE;
    do_slot(1'b1);

    finish_run();
  end
endmodule